// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a cycle-accurate, synthesizable model of a pipelined synchronous SRAM. It has a two-bit burst address counter and deselects in a single cycle. Every control input, the address and the write data are captured on the rising clock edge. The storage array is small and split into independent byte lanes. By default it is 1024 words of 36 bits, arranged as four lanes of 9 bits each. Read data comes back through an output register. Output drive is reported as a flag next to the data bus, and there are no real tristate pads.

A burst can be opened by either of two load strobes, one for a host and one for a controller. The two strobes follow different priority and masking rules. After a burst is open, the advance input either steps the counter or holds the current address, and the write inputs choose read or write on every beat. The counter steps in linear order or in interleaved order. Reads issued with the output enable high still move the burst forward, so they can serve as dummy reads.

Top module: `pburst_sram`

## Requirements
- R1: The low two address bits captured on a burst-opening cycle give the start offset. With `ilv_mode`=0, beat k of the burst (k = 0..3) accesses offset (start + k) mod 4. The upper address bits do not change during the burst.
- R2: With `ilv_mode`=1, beat k accesses offset start XOR k. In both modes a fifth stepping beat returns to the start offset.
- R3: The host strobe is ignored while `cs1_n` is high, and the cycle then acts as a burst cycle. The controller strobe is always honoured. If `cs1_n` is high on a controller strobe cycle, that cycle is a deselect and performs no access.
- R4: `cs2` (active high) and `cs3_n` (active low) are evaluated only on strobe cycles. A strobe cycle with `cs2`=0 or `cs3_n`=1 deselects, and changes to these inputs on other cycles have no effect.
- R5: A cycle opened by the host strobe is always a read, whatever the write inputs are.
- R6: On an enabled cycle with no strobe, `adv_n`=0 steps the counter and `adv_n`=1 repeats the current address. The write inputs decide read or write on these cycles.
- R7: `wr_all_n`=0 writes all lanes. Otherwise, if `wr_lane_en_n`=0, only the lanes whose `wr_lane_n` bit is 0 are written (lane i is `wdata[9i+8:9i]`). Any other combination makes the cycle a read.
- R8: Data for a read sampled at edge N is on `rdata` after edge N+1. Back-to-back burst beats deliver one word per cycle.
- R9: `rdata_drv` is high only while `oe_n` is low and the access one stage earlier was a read. It stays low after writes, whatever the lane enables are.
- R10: Reads made with `oe_n` high step the counter exactly as normal reads do.
- R11: After a deselect is captured at edge N, `rdata_drv` is low from edge N+1 on, with no extra idle cycle.
- R12: While reset is held and after it is released, `rdata_drv` is low and no burst is open. A stepping write cycle with no strobe then changes no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address, captured on strobe cycles |
| cs1_n | input | 1 | Chip select 1, active low; also masks the host strobe |
| cs2 | input | 1 | Chip select 2, active high, evaluated on strobe cycles |
| cs3_n | input | 1 | Chip select 3, active low, evaluated on strobe cycles |
| ld_host_n | input | 1 | Host load strobe, active low |
| ld_ctl_n | input | 1 | Controller load strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ilv_mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_lane_en_n | input | 1 | Per-lane write qualifier, active low |
| wr_lane_n | input | LANES | Per-lane write selects, active low |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Output enable, active low, combinational |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_drv | output | 1 | High when `rdata` would be driven |

## Verification
The bench builds the block with its default parameters: a 10-bit address and four 9-bit lanes. The whole array is filled with an address-derived pattern in about a thousand cycles, so every read word shows which address produced it. With only four lanes, every single-lane and mixed-lane write pattern can be reached. With a small array, bursts at all four start offsets in both orders can each be checked beat by beat and confirmed to wrap.

// File: rtl/pbs_pkg.sv
// Shared types and helpers for the pipelined burst SRAM.
// Assumes a two-bit burst counter; nothing here depends on array size.
package pbs_pkg;

    // Classification of one sampled cycle.
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_DESEL = 2'd1,
        CYC_BEGIN = 2'd2,
        CYC_BURST = 2'd3
    } cyc_kind_t;

    // Offset of beat k within a burst that started at offset st.
    function automatic logic [1:0] burst_off(input logic [1:0] st,
                                             input logic [1:0] k,
                                             input logic       ilv);
        logic [1:0] r;
        if (ilv) r = st ^ k;
        else     r = st + k;
        return r;
    endfunction

endpackage

// File: rtl/pbs_ctrl.sv
// Cycle decoder: classifies each sampled cycle (begin, burst, deselect,
// idle) and resolves read versus write and the lanes to write.
// Holds the "burst open" flag. Assumes inputs meet setup at the clock edge.
module pbs_ctrl
    import pbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs1_n,
    input  logic             cs2,
    input  logic             cs3_n,
    input  logic             ld_host_n,
    input  logic             ld_ctl_n,
    input  logic             adv_n,
    input  logic             wr_all_n,
    input  logic             wr_lane_en_n,
    input  logic [LANES-1:0] wr_lane_n,
    output logic             load,
    output logic             step,
    output logic             access,
    output logic             is_wr,
    output logic [LANES-1:0] lane_be
);

    logic      open_q;
    logic      host_go;
    logic      ctl_go;
    logic      strobe;
    logic      sel_ok;
    logic      wr_req;
    cyc_kind_t kind;

    // Decide which strobe, if any, owns this cycle and whether it selects.
    always_comb begin
        host_go = !ld_host_n && !cs1_n;
        ctl_go  = !ld_ctl_n && !host_go;
        strobe  = host_go || ctl_go;
        sel_ok  = !cs1_n && cs2 && !cs3_n;
        wr_req  = !wr_all_n || (!wr_lane_en_n && (wr_lane_n != {LANES{1'b1}}));
    end

    // Classify the cycle and derive the access controls.
    always_comb begin
        if (strobe)      kind = sel_ok ? CYC_BEGIN : CYC_DESEL;
        else if (open_q) kind = CYC_BURST;
        else             kind = CYC_IDLE;
        load    = (kind == CYC_BEGIN);
        step    = (kind == CYC_BURST) && !adv_n;
        access  = (kind == CYC_BEGIN) || (kind == CYC_BURST);
        is_wr   = ((kind == CYC_BEGIN) && ctl_go && wr_req) ||
                  ((kind == CYC_BURST) && wr_req);
        lane_be = !wr_all_n ? {LANES{1'b1}} : ~wr_lane_n;
    end

    // Track whether a burst is open; only strobe cycles change it.
    always_ff @(posedge clk) begin
        if (!rst_n)      open_q <= 1'b0;
        else if (strobe) open_q <= sel_ok;
    end

    // R3: a controller strobe with cs1_n high leaves the next plain cycle idle.
    assert_ctl_strobe_deselects_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_ctl_n && cs1_n) ##1 ((ld_host_n || cs1_n) && ld_ctl_n) |-> !access);

    // R4: a strobe with cs2 low deselects the next plain cycle as well.
    assert_cs2_low_deselects_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_ctl_n && !cs2) ##1 ((ld_host_n || cs1_n) && ld_ctl_n) |-> !access);

endmodule

// File: rtl/pbs_burst_ctr.sv
// Burst address generator. It loads the upper address and the start offset
// on a burst-opening cycle and counts beats. The live offset is recomputed
// from start and count in linear or interleaved order. Outputs the
// address of the current access.
module pbs_burst_ctr
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              ilv_mode,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam int HI_W = ADDR_W - 2;

    logic [HI_W-1:0] hi_q;
    logic [1:0]      st_q;
    logic [1:0]      cnt_q;
    logic [1:0]      cnt_nxt;

    // Next beat count and the address used on this cycle.
    always_comb begin
        if (load)      cnt_nxt = 2'd0;
        else if (step) cnt_nxt = 2'(cnt_q + 2'd1);
        else           cnt_nxt = cnt_q;
        cur_addr = load ? ext_addr : {hi_q, burst_off(st_q, cnt_nxt, ilv_mode)};
    end

    // Hold burst base, start offset and beat count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            st_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (load) begin
                hi_q <= ext_addr[ADDR_W-1:2];
                st_q <= ext_addr[1:0];
            end
            cnt_q <= cnt_nxt;
        end
    end

    // R2: four consecutive steps in one mode land on the same address again.
    assert_wrap_after_four_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && $past(step) && $past(step, 2) && $past(step, 3) &&
         (ilv_mode == $past(ilv_mode, 4)))
        |-> cur_addr == $past(cur_addr, 4));

    // R6: a hold cycle right after a load repeats the loaded address.
    assert_suspend_repeats_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load) && !load && !step && (ilv_mode == $past(ilv_mode)))
        |-> cur_addr == $past(ext_addr));

endmodule

// File: rtl/pbs_lane_array.sv
// Byte-lane storage array. Each lane is its own memory. Writes commit the
// selected lanes, and reads load a registered output word. Only one of
// read or write is requested per cycle. The array is not reset, only the
// output register is.
module pbs_lane_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        be,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata_q
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Commit this lane's byte when it is enabled for the write.
        always_ff @(posedge clk) begin
            if (wr_en && be[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        // Register this lane's read word.
        always_ff @(posedge clk) begin
            if (!rst_n)     rdata_q[g*LANE_W +: LANE_W] <= '0;
            else if (rd_en) rdata_q[g*LANE_W +: LANE_W] <= mem[addr];
        end
    end

endmodule

// File: rtl/pburst_sram.sv
// Pipelined single-cycle-deselect burst SRAM, top level. Stage 1 captures
// the decoded access (address, direction, lanes, data) at the sampling
// edge. Stage 2 commits writes or registers read data at the next edge.
// Output enable gates the registered drive flag combinationally.
module pburst_sram
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    ld_host_n,
    input  logic                    ld_ctl_n,
    input  logic                    adv_n,
    input  logic                    ilv_mode,
    input  logic                    wr_all_n,
    input  logic                    wr_lane_en_n,
    input  logic [LANES-1:0]        wr_lane_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_drv
);

    localparam int DW = LANES * LANE_W;

    logic              load;
    logic              step;
    logic              access;
    logic              is_wr;
    logic [LANES-1:0]  lane_be;
    logic [ADDR_W-1:0] cur_addr;

    logic              acc_vld_q;
    logic              acc_wr_q;
    logic [ADDR_W-1:0] acc_addr_q;
    logic [LANES-1:0]  acc_be_q;
    logic [DW-1:0]     acc_wd_q;
    logic              drv_q;
    logic [DW-1:0]     rd_q;

    pbs_ctrl #(.LANES(LANES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs1_n        (cs1_n),
        .cs2          (cs2),
        .cs3_n        (cs3_n),
        .ld_host_n    (ld_host_n),
        .ld_ctl_n     (ld_ctl_n),
        .adv_n        (adv_n),
        .wr_all_n     (wr_all_n),
        .wr_lane_en_n (wr_lane_en_n),
        .wr_lane_n    (wr_lane_n),
        .load         (load),
        .step         (step),
        .access       (access),
        .is_wr        (is_wr),
        .lane_be      (lane_be)
    );

    pbs_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .ilv_mode (ilv_mode),
        .ext_addr (addr),
        .cur_addr (cur_addr)
    );

    // Stage 1: capture the decoded access of this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_vld_q  <= 1'b0;
            acc_wr_q   <= 1'b0;
            acc_addr_q <= '0;
            acc_be_q   <= '0;
            acc_wd_q   <= '0;
        end else begin
            acc_vld_q  <= access;
            acc_wr_q   <= is_wr;
            acc_addr_q <= cur_addr;
            acc_be_q   <= lane_be;
            acc_wd_q   <= wdata;
        end
    end

    pbs_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc_vld_q && acc_wr_q),
        .rd_en   (acc_vld_q && !acc_wr_q),
        .addr    (acc_addr_q),
        .be      (acc_be_q),
        .wdata   (acc_wd_q),
        .rdata_q (rd_q)
    );

    // Stage 2 drive flag: set when the word in the output register is a read.
    always_ff @(posedge clk) begin
        if (!rst_n) drv_q <= 1'b0;
        else        drv_q <= acc_vld_q && !acc_wr_q;
    end

    // Output enable gates the drive flag without a clock.
    always_comb begin
        rdata     = rd_q;
        rdata_drv = drv_q && !oe_n;
    end

    // R9: the cycle after a committed write never drives.
    assert_no_drive_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld_q && acc_wr_q) |=> !rdata_drv);

    // R5: a host-strobe cycle never produces a write access.
    assert_host_strobe_reads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_host_n && !cs1_n) |=> (!acc_vld_q || !acc_wr_q));

    // R11: drive is gone two edges after a captured deselect.
    assert_deselect_stops_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_ctl_n && cs1_n) |-> ##2 !rdata_drv);

    // R8: any drive traces back to a read access one edge earlier.
    assert_drive_follows_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_drv |-> $past(acc_vld_q && !acc_wr_q));

endmodule

// File: tb/pburst_sram_tb.sv
module pburst_sram_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          cs1_n, cs2, cs3_n, ld_host_n, ld_ctl_n, adv_n, ilv_mode;
    logic          wr_all_n, wr_lane_en_n, oe_n;
    logic [NL-1:0] wr_lane_n;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          rdata_drv;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pburst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs1_n(cs1_n), .cs2(cs2),
        .cs3_n(cs3_n), .ld_host_n(ld_host_n), .ld_ctl_n(ld_ctl_n),
        .adv_n(adv_n), .ilv_mode(ilv_mode), .wr_all_n(wr_all_n),
        .wr_lane_en_n(wr_lane_en_n), .wr_lane_n(wr_lane_n), .wdata(wdata),
        .oe_n(oe_n), .rdata(rdata), .rdata_drv(rdata_drv)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return (36'(a) * 36'h013579) ^ 36'hA5A5A5A5A;
    endfunction

    // Behavioural reference: memory, burst state and a two-deep pipe.
    logic [DW-1:0] ref_mem [0:(1<<AW)-1];
    int            m_en, m_hi, m_st, m_cnt;
    int            p_vld, p_wr, p_addr;
    logic [NL-1:0] p_be;
    logic [DW-1:0] p_wd;
    int            e_drv;
    logic [DW-1:0] e_dout;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_hi = 0; m_st = 0; m_cnt = 0;
            p_vld = 0; p_wr = 0; e_drv = 0; e_dout = '0;
        end else begin
            bit cpu, strobe, ok, wreq;
            if (p_vld != 0 && p_wr != 0)
                for (int l = 0; l < NL; l++)
                    if (p_be[l]) ref_mem[p_addr][l*LW +: LW] = p_wd[l*LW +: LW];
            e_drv = (p_vld != 0 && p_wr == 0) ? 1 : 0;
            if (e_drv != 0) e_dout = ref_mem[p_addr];
            cpu    = !ld_host_n && !cs1_n;
            strobe = cpu || !ld_ctl_n;
            ok     = !cs1_n && cs2 && !cs3_n;
            wreq   = !wr_all_n || (!wr_lane_en_n && wr_lane_n != 4'hF);
            p_vld  = 0;
            if (strobe) begin
                m_en = ok ? 1 : 0;
                if (ok) begin
                    m_hi = int'(addr) / 4; m_st = int'(addr) % 4; m_cnt = 0;
                    p_vld = 1; p_wr = (!cpu && wreq) ? 1 : 0; p_addr = int'(addr);
                end
            end else if (m_en != 0) begin
                if (!adv_n) m_cnt = (m_cnt + 1) % 4;
                p_vld  = 1;
                p_wr   = wreq ? 1 : 0;
                p_addr = m_hi * 4 + (ilv_mode ? (m_st ^ m_cnt) : ((m_st + m_cnt) % 4));
            end
            p_be = !wr_all_n ? 4'hF : ~wr_lane_n;
            p_wd = wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: edge, then compare outputs against the reference (R8, R9).
    task automatic tick();
        bit ed;
        @(posedge clk);
        @(negedge clk);
        ed = (e_drv != 0) && !oe_n;
        chk(rdata_drv == ed, "R9 drive vs model", DW'(rdata_drv), DW'(ed));
        if (ed) chk(rdata == e_dout, "R8 data vs model", rdata, e_dout);
    endtask

    task automatic set_none();
        ld_host_n = 1; ld_ctl_n = 1; cs1_n = 0; cs2 = 1; cs3_n = 0;
        adv_n = 1; wr_all_n = 1; wr_lane_en_n = 1; wr_lane_n = '1;
        oe_n = 0; wdata = '0; addr = '0;
    endtask

    task automatic desel();
        set_none(); ld_ctl_n = 0; cs1_n = 1;
    endtask

    task automatic rd1(input int a, output logic [DW-1:0] d, output logic v);
        set_none(); ld_ctl_n = 0; addr = AW'(a); tick();
        desel(); tick();
        d = rdata; v = rdata_drv;
        desel(); tick();
    endtask

    task automatic burst_chk(input int base, input bit ilv);
        int exp_a;
        ilv_mode = ilv;
        set_none(); ld_ctl_n = 0; addr = AW'(base); tick();
        for (int j = 1; j <= 6; j++) begin
            if (j <= 4) begin set_none(); adv_n = 0; end
            else desel();
            tick();
            if (j <= 5) begin
                int k = (j - 1) % 4;
                int s = base % 4;
                exp_a = (base / 4) * 4 + (ilv ? (s ^ k) : ((s + k) % 4));
                chk(rdata_drv == 1'b1 && rdata == pat(exp_a),
                    ilv ? "R2 interleaved beat" : "R1 linear beat", rdata, pat(exp_a));
            end else begin
                chk(rdata_drv == 1'b0, "R11 drive off after deselect", DW'(rdata_drv), '0);
            end
        end
    endtask

    initial begin
        logic [DW-1:0] d, x;
        logic          v;
        ilv_mode = 0;
        set_none();
        rst_n = 0;
        repeat (3) tick();
        chk(rdata_drv == 1'b0, "R12 reset drive", DW'(rdata_drv), '0);
        rst_n = 1;

        // Fill every word with its pattern.
        for (int a = 0; a < (1 << AW); a++) begin
            set_none(); ld_ctl_n = 0; wr_all_n = 0; addr = AW'(a); wdata = pat(a);
            tick();
        end
        desel(); tick(); tick();

        // R12: after reset no burst is open; a stepping write does nothing.
        set_none(); rst_n = 0; tick(); rst_n = 1;
        set_none(); adv_n = 0; wr_all_n = 0; wdata = '0; tick();
        chk(rdata_drv == 1'b0, "R12 no drive after reset", DW'(rdata_drv), '0);
        rd1(0, d, v);
        chk(v && d == pat(0), "R12 memory untouched", d, pat(0));

        // R1/R2/R11: all start offsets in both orders.
        for (int s = 0; s < 4; s++) begin
            burst_chk(16'h40 + s, 1'b0);
            burst_chk(16'h60 + s, 1'b1);
        end

        // R10: dummy reads with oe_n high still step.
        ilv_mode = 0;
        set_none(); ld_ctl_n = 0; addr = AW'(16'h80); oe_n = 1; tick();
        set_none(); adv_n = 0; oe_n = 1; tick();
        chk(rdata_drv == 1'b0, "R10 dummy read not driven", DW'(rdata_drv), '0);
        set_none(); adv_n = 0; oe_n = 1; tick();
        set_none(); adv_n = 0; tick();
        chk(rdata_drv && rdata == pat(16'h82), "R10 counter stepped on dummy", rdata, pat(16'h82));
        desel(); tick();
        chk(rdata_drv && rdata == pat(16'h83), "R10 next beat", rdata, pat(16'h83));
        desel(); tick();

        // R6/R7/R9: write burst with full, partial, held and non-write cycles.
        set_none(); ld_ctl_n = 0; wr_all_n = 0; addr = AW'(16'h100); wdata = 36'h123456789; tick();
        set_none(); adv_n = 0; wr_lane_en_n = 0; wr_lane_n = 4'b1010; wdata = 36'hFEDCBA987; tick();
        chk(rdata_drv == 1'b0, "R9 no drive after write", DW'(rdata_drv), '0);
        set_none(); wr_lane_en_n = 0; wr_lane_n = 4'b1101; wdata = 36'h0F0F0F0F0; tick();
        set_none(); adv_n = 0; wr_lane_n = 4'b0000; wdata = 36'h111111111; tick();
        desel(); tick();
        chk(rdata_drv && rdata == pat(16'h102), "R7 lanes without qualifier read", rdata, pat(16'h102));
        desel(); tick();
        rd1(16'h100, d, v);
        chk(v && d == 36'h123456789, "R7 all-lane write", d, 36'h123456789);
        x = pat(16'h101);
        x[8:0] = 9'(36'hFEDCBA987); x[26:18] = 9'(36'hFEDCBA987 >> 18);
        x[17:9] = 9'(36'h0F0F0F0F0 >> 9);
        rd1(16'h101, d, v);
        chk(v && d == x, "R6 held write hits same word, R7 lane merge", d, x);
        rd1(16'h102, d, v);
        chk(v && d == pat(16'h102), "R7 read cycle wrote nothing", d, pat(16'h102));

        // R5: host strobe with write inputs is a read.
        set_none(); ld_host_n = 0; wr_all_n = 0; addr = AW'(16'h200); tick();
        desel(); tick();
        chk(rdata_drv && rdata == pat(16'h200), "R5 host strobe read", rdata, pat(16'h200));
        desel(); tick();
        rd1(16'h200, d, v);
        chk(v && d == pat(16'h200), "R5 memory kept", d, pat(16'h200));

        // R3: host strobe masked by cs1_n acts as a burst step.
        set_none(); ld_ctl_n = 0; addr = AW'(16'h300); tick();
        set_none(); ld_host_n = 0; cs1_n = 1; adv_n = 0; addr = AW'(16'h3F0); tick();
        chk(rdata_drv && rdata == pat(16'h300), "R3 first beat", rdata, pat(16'h300));
        desel(); tick();
        chk(rdata_drv && rdata == pat(16'h301), "R3 masked host strobe continued", rdata, pat(16'h301));
        desel(); tick();

        // R4: strobe with cs2 low deselects; cs changes off-strobe are ignored.
        set_none(); ld_ctl_n = 0; addr = AW'(16'h304); tick();
        set_none(); ld_ctl_n = 0; cs2 = 0; addr = AW'(16'h310); tick();
        set_none(); adv_n = 0; tick();
        chk(rdata_drv == 1'b0, "R4 cs2 low deselects", DW'(rdata_drv), '0);
        set_none(); ld_ctl_n = 0; addr = AW'(16'h320); tick();
        set_none(); adv_n = 0; cs2 = 0; cs3_n = 1; tick();
        desel(); tick();
        chk(rdata_drv && rdata == pat(16'h321), "R4 selects ignored off-strobe", rdata, pat(16'h321));
        desel(); tick(); tick();

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule